// File: doc/BRIEF.md
# Event Fragmenter with Continuation Flag

This block takes whole events of any length as a stream of 16-bit words, with a marker on the final word of each event. It re-emits each event as one or more fragments. Each fragment fits a 2048-word output FIFO. Every fragment begins with a length word. That word packs a 3-bit stack identifier, a continuation flag and the number of words that follow it in the fragment. The first fragment of an event also carries an event header: the crate origin marker 0xE800, followed by a 64-bit event counter sent as four 16-bit words.

The block stores each fragment internally before sending it, because the length word must go out before the payload. While a fragment is being sent, input is held off. A one-cycle close request makes the block close the current buffer with two 0xFFFF words. These go out once the event in progress has been fully sent, or at once if no event is in progress.

Top module: `evt_fragmenter`

## Requirements
- R1: The length word opening each fragment has the stack identifier in bits 15-13, the continuation flag in bit 12, and in bits 11-0 the count of words that follow the length word in that fragment (the length word itself is not counted).
- R2: No fragment has more than 2048 words after its length word. In the first fragment, the 5 header words count toward that limit, so it holds at most 2043 payload words. Payload words appear in input order.
- R3: The continuation flag is 1 on every fragment of an event except the last, where it is 0. This includes an event that exactly fills its last fragment.
- R4: In the first fragment of an event, the word after the length word is 0xE800. Later fragments of the same event carry no header and go straight to payload.
- R5: The four words after 0xE800 are the 64-bit event counter, least significant word first. The counter is 0 after reset and advances by one per complete event, not per fragment.
- R6: The stack identifier is captured with the first input word of an event and used in every fragment of that event, whatever the input does later.
- R7: A pulse on buf_close_i produces exactly two 0xFFFF words. They come after the last fragment of the event being sent, or at once when the block is idle, and before any word of a later event.
- R8: in_ready_o is low whenever out_valid_o is high. A fragment's words are emitted on consecutive cycles with no gaps.
- R9: After reset, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word present |
| in_data_i | input | 16 | Input event word |
| in_last_i | input | 1 | Marks the final word of an event |
| in_ready_o | output | 1 | Input word accepted when high together with in_valid_i |
| stack_id_i | input | 3 | Stack identifier for the event starting now |
| buf_close_i | input | 1 | One-cycle request to close the buffer with two terminators |
| out_valid_o | output | 1 | Output word present |
| out_data_o | output | 16 | Output word |

## Verification
The bench targets fragment boundaries. It sends a 2043-word event that exactly fills the first fragment; a design that sets the flag when the buffer fills, rather than when more data follows, would wrongly mark it as continued. A 2044-word event leaves a one-word second fragment, which catches an off-by-one in the length count or an extra header copied into later fragments. A 4100-word event spans three fragments and shows whether the counter advances per event or per fragment. The bench also changes the stack identifier in the middle of an event, and issues close requests both while idle and while a fragment is being sent. These catch a design that picks up the new identifier late, or that lets terminators interrupt a fragment.

// File: rtl/evt_frag_pkg.sv
package evt_frag_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 12;
  localparam int SID_W  = 3;
  localparam logic [WORD_W-1:0] ORIGIN_WORD = 16'hE800;
  localparam logic [WORD_W-1:0] TERM_WORD   = 16'hFFFF;

  typedef enum logic [1:0] {
    S_FILL = 2'd0,
    S_EMIT = 2'd1,
    S_TERM = 2'd2
  } frag_state_e;
endpackage

// File: rtl/evt_frag_buf.sv
module evt_frag_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 2048
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 16,
  localparam int NSEL  = CNT_W / WORD_W,
  localparam int SW    = (NSEL > 1) ? $clog2(NSEL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic [SW-1:0]     sel_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] words [NSEL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_slice
    assign words[g] = cnt_q[g*WORD_W +: WORD_W];
  end

  assign word_o  = words[sel_i];
  assign count_o = cnt_q;
endmodule

// File: rtl/evt_fragmenter.sv
module evt_fragmenter
  import evt_frag_pkg::*;
#(
  parameter int FRAG_MAX = 2048,
  parameter int CNT_W    = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  input  logic [SID_W-1:0]  stack_id_i,
  input  logic              buf_close_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o
);
  localparam int NSEL      = CNT_W / WORD_W;
  localparam int SW        = (NSEL > 1) ? $clog2(NSEL) : 1;
  localparam int HDR_WORDS = 1 + NSEL;
  localparam int AW        = $clog2(FRAG_MAX);
  localparam int CW        = $clog2(FRAG_MAX + 1);
  localparam int PW        = $clog2(FRAG_MAX + HDR_WORDS + 1);

  frag_state_e       state_q;
  logic [CW-1:0]     fill_q;
  logic [PW-1:0]     pos_q;
  logic [SID_W-1:0]  sid_q;
  logic              first_q, cont_q, pend_q, term_idx_q;

  logic              accept, frag_done, emit_end, len_word, term_first, idle_close;
  logic [CW:0]       cap, fill_inc;
  logic [PW-1:0]     hdr_n, last_pos;
  logic [AW-1:0]     raddr;
  logic [SW-1:0]     cnt_sel;
  logic [WORD_W-1:0] buf_word, cnt_word;
  logic [CNT_W-1:0]  evt_cnt;

  assign idle_close = pend_q && first_q && (fill_q == '0);
  assign in_ready_o = (state_q == S_FILL) && !idle_close;
  assign accept     = in_valid_i && in_ready_o;
  // first fragment loses room to the header words
  assign cap        = first_q ? (CW+1)'(FRAG_MAX - HDR_WORDS) : (CW+1)'(FRAG_MAX);
  assign fill_inc   = {1'b0, fill_q} + (CW+1)'(1);
  assign frag_done  = accept && (in_last_i || (fill_inc == cap));

  assign hdr_n      = first_q ? PW'(HDR_WORDS) : '0;
  assign last_pos   = hdr_n + PW'(fill_q);
  assign emit_end   = (state_q == S_EMIT) && (pos_q == last_pos);
  assign len_word   = (state_q == S_EMIT) && (pos_q == '0);
  assign term_first = (state_q == S_TERM) && !term_idx_q;
  assign raddr      = AW'(pos_q - hdr_n - PW'(1));
  assign cnt_sel    = SW'(pos_q - PW'(2));

  evt_frag_buf #(.DW(WORD_W), .DEPTH(FRAG_MAX)) u_buf (
    .clk_i   (clk_i),
    .we_i    (accept),
    .waddr_i (AW'(fill_q)),
    .wdata_i (in_data_i),
    .raddr_i (raddr),
    .rdata_o (buf_word)
  );

  evt_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (emit_end && !cont_q),
    .sel_i   (cnt_sel),
    .word_o  (cnt_word),
    .count_o (evt_cnt)
  );

  assign out_valid_o = (state_q != S_FILL);

  always_comb begin
    if (state_q == S_TERM)                           out_data_o = TERM_WORD;
    else if (pos_q == '0)                            out_data_o = {sid_q, cont_q, LEN_W'(last_pos)};
    else if (first_q && pos_q == PW'(1))             out_data_o = ORIGIN_WORD;
    else if (first_q && pos_q <= PW'(HDR_WORDS))     out_data_o = cnt_word;
    else                                             out_data_o = buf_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_FILL;
      fill_q     <= '0;
      pos_q      <= '0;
      sid_q      <= '0;
      first_q    <= 1'b1;
      cont_q     <= 1'b0;
      pend_q     <= 1'b0;
      term_idx_q <= 1'b0;
    end else begin
      pend_q <= buf_close_i || (pend_q && !((state_q == S_TERM) && term_idx_q));
      unique case (state_q)
        S_FILL: begin
          if (accept) begin
            fill_q <= fill_inc[CW-1:0];
            if (first_q && fill_q == '0) sid_q <= stack_id_i;
            if (frag_done) begin
              state_q <= S_EMIT;
              cont_q  <= !in_last_i;
              pos_q   <= '0;
            end
          end else if (idle_close) begin
            state_q    <= S_TERM;
            term_idx_q <= 1'b0;
          end
        end
        S_EMIT: begin
          pos_q <= pos_q + PW'(1);
          if (emit_end) begin
            pos_q   <= '0;
            fill_q  <= '0;
            first_q <= !cont_q;
            state_q <= S_FILL;
          end
        end
        S_TERM: begin
          term_idx_q <= 1'b1;
          if (term_idx_q) begin
            term_idx_q <= 1'b0;
            state_q    <= S_FILL;
          end
        end
        default: state_q <= S_FILL;
      endcase
    end
  end
endmodule

// File: rtl/evt_fragmenter_chk.sv
module evt_fragmenter_chk #(
  parameter int FRAG_MAX = 2048,
  parameter int CNT_W    = 64,
  localparam int CW      = $clog2(FRAG_MAX + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic [15:0]      out_data_o,
  input logic             len_word,
  input logic             term_first,
  input logic [CNT_W-1:0] evt_cnt,
  input logic [CW-1:0]    fill_q
);
  // R8
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  // R2
  frag_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CW'(FRAG_MAX));

  // R3
  cont_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_word && out_data_o[12]) |-> (out_data_o[11:0] == 12'(FRAG_MAX)));

  // R1
  len_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_word |-> (out_data_o[11:0] != 12'd0));

  // R5
  evt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_cnt != $past(evt_cnt)) |-> (evt_cnt == $past(evt_cnt) + CNT_W'(1)));

  // R7
  term_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_first |=> (out_valid_o && out_data_o == 16'hFFFF));
endmodule

bind evt_fragmenter evt_fragmenter_chk #(.FRAG_MAX(FRAG_MAX), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .len_word    (len_word),
  .term_first  (term_first),
  .evt_cnt     (evt_cnt),
  .fill_q      (fill_q)
);

// File: tb/evt_fragmenter_bench.sv
module evt_fragmenter_bench;
  localparam int FRAG = 2048;
  localparam int HDR  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [2:0]  stack_id = '0;
  logic        buf_close = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;

  int          checks = 0;
  int          errors = 0;
  int          ev_id  = 0;
  logic [63:0] exp_cnt = '0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  evt_fragmenter u_evt_fragmenter (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .in_last_i   (in_last),
    .in_ready_o  (in_ready),
    .stack_id_i  (stack_id),
    .buf_close_i (buf_close),
    .out_valid_o (out_valid),
    .out_data_o  (out_data)
  );

  function automatic logic [15:0] pay(int e, int i);
    return 16'((e * 97 + i * 3 + 1) & 32'hFFFF);
  endfunction

  task automatic push_exp(logic [15:0] d, string t);
    exp_q.push_back(d);
    tag_q.push_back(t);
  endtask

  task automatic check(bit ok, string t, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // monitor: pop and compare each emitted word
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (in_ready) check(1'b0, "R8", {15'd0, in_ready}, 16'd0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", out_data, 16'hxxxx);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data === e, t, out_data, e);
      end
    end
  end

  task automatic push_word(logic [15:0] d, logic last);
    bit ok;
    in_valid = 1'b1;
    in_data  = d;
    in_last  = last;
    do begin
      ok = in_ready;
      @(posedge clk);
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  // driver: queue the expected fragments, then feed the event
  task automatic send_event(int n, logic [2:0] sid, logic [2:0] sid_late, string ltag);
    int  rem = n;
    int  idx = 0;
    bit  first = 1'b1;
    while (rem > 0) begin
      int cap  = first ? FRAG - HDR : FRAG;
      int take = (rem < cap) ? rem : cap;
      bit cont = (rem > cap);
      push_exp({sid, cont, 12'(take + (first ? HDR : 0))}, ltag);
      if (first) begin
        push_exp(16'hE800, "R4");
        for (int k = 0; k < 4; k++) push_exp(exp_cnt[16*k +: 16], "R5");
      end
      for (int j = 0; j < take; j++) begin
        push_exp(pay(ev_id, idx), "R2");
        idx++;
      end
      rem  -= take;
      first = 1'b0;
    end
    exp_cnt++;
    for (int i = 0; i < n; i++) begin
      stack_id = (i == 0) ? sid : sid_late;
      push_word(pay(ev_id, i), i == n - 1);
    end
    ev_id++;
  endtask

  task automatic close_buf();
    push_exp(16'hFFFF, "R7");
    push_exp(16'hFFFF, "R7");
    buf_close = 1'b1;
    @(negedge clk);
    buf_close = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected drain");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0, "R9", {15'd0, out_valid}, 16'd0);
    check(in_ready == 1'b1, "R9", {15'd0, in_ready}, 16'd1);

    close_buf();                       // R7 while idle
    send_event(1, 3'd5, 3'd5, "R1");   // R5 counter 0
    send_event(3, 3'd2, 3'd7, "R6");   // stack changes after first word
    send_event(2043, 3'd1, 3'd1, "R3"); // exact fit, flag clear
    send_event(2044, 3'd4, 3'd4, "R3"); // one-word tail fragment
    close_buf();                       // R7 during emission
    send_event(4100, 3'd6, 3'd6, "R3"); // three fragments, one count step
    close_buf();
    send_event(2, 3'd3, 3'd3, "R1");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    // R8 idle after drain
    check(out_valid == 1'b0, "R8", {15'd0, out_valid}, 16'd0);
    check(in_ready == 1'b1, "R8", {15'd0, in_ready}, 16'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule